// File: doc/BRIEF.md
# DMA-Snooping Cache Tag Unit

This block holds the tag and state of a small direct-mapped write-back cache and watches a shared memory bus on which a DMA engine issues read and write cycles. Each line keeps a valid bit, a dirty bit and a tag. A processor port performs lookups, fills lines and marks resident lines dirty. A separate snoop port looks up the tag of every address seen on the bus in the same cycle, in parallel with the processor access, so snooping never stalls the processor.

For every observed DMA cycle the block chooses a coherence action from the cycle type and the line's state. A snoop miss does nothing. A read that hits a clean line does nothing, because memory is already current. A read that hits a dirty line makes the cache intervene: it tells memory to stay silent for one cycle and then drives the line's data onto the bus. A DMA write that hits any line purges the copy. A dirty copy is dropped without a write-back, because the DMA write replaces the location in memory. The data array exists only to supply intervention data. The processor writes it on fills and on write hits.

An address splits into index `addr[IDX_W-1:0]` and tag `addr[ADDR_W-1:IDX_W]`. With the default parameters there are 16 lines, one 32-bit word per line.

Top module: `dma_snoop_tags`

## Requirements
- R1: After a synchronous active-high reset every line is invalid and clean. `cpu_resp_valid`, `cpu_hit`, `cpu_dirty`, `mem_inhibit`, `bus_drive` and `bus_data_out` are all zero.
- R2: `cpu_op` = 2 (fill) makes the line at the address's index valid and clean, and stores the tag and `cpu_wdata`. A later `cpu_op` = 1 (lookup) to the same address gives `cpu_hit`=1 and `cpu_dirty`=0. A lookup with a different tag at the same index misses. Every non-zero op sets `cpu_resp_valid` one cycle later, and `cpu_hit`/`cpu_dirty` then report the line's state before that op.
- R3: `cpu_op` = 3 (write) to a resident line sets its dirty bit and stores `cpu_wdata`. A write to an address that is not resident changes no line.
- R4: A bus cycle (`bus_valid`=1) whose address misses causes no inhibit, no drive and no state change.
- R5: A DMA read (`bus_we`=0) that hits a clean line causes no inhibit or drive, and the line stays valid and clean.
- R6: A DMA read that hits a dirty line raises `mem_inhibit` for one cycle, starting one clock after the bus cycle is sampled. In the cycle after that, `bus_drive` is 1 and `bus_data_out` carries the line data as it was when the snoop was sampled. The line stays valid and dirty.
- R7: A DMA write (`bus_we`=1) that hits a clean line invalidates it.
- R8: A DMA write that hits a dirty line invalidates it without any inhibit or drive.
- R9: `bus_data_out` is zero in every cycle in which `bus_drive` is 0.
- R10: When a snoop invalidation and a processor fill or write hit the same index in the same cycle, the line ends up invalid.
- R11: A processor access and a snoop in the same cycle are both served in that cycle. Both see the line state from before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_op | input | 2 | 0 idle, 1 lookup, 2 fill, 3 write |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Fill or write data |
| cpu_resp_valid | output | 1 | Response for the op of the previous cycle |
| cpu_hit | output | 1 | Line was valid with a matching tag |
| cpu_dirty | output | 1 | Line was hit and dirty |
| bus_valid | input | 1 | A DMA cycle is on the bus |
| bus_we | input | 1 | 1 = DMA write, 0 = DMA read |
| bus_addr | input | ADDR_W | Address of the DMA cycle |
| mem_inhibit | output | 1 | Memory must not answer (intervention) |
| bus_drive | output | 1 | Cache drives the bus data lines |
| bus_data_out | output | DATA_W | Intervention data, zero when not driving |

## Verification
The assertions assume the processor issues at most one op per cycle and drives `cpu_addr` and `bus_addr` with defined values whenever the op or `bus_valid` is active. They also assume `bus_we` is meaningful only while `bus_valid` is high. The stimulus drives every input at the falling edge from a single task, with ops taken from the four legal codes. Addresses are drawn from a few tags over a few indices, so snoop hits, dirty interventions and same-index collisions between the two ports come up often.

// File: rtl/dst_pkg.sv
package dst_pkg;
  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_LOOKUP = 2'd1,
    OP_FILL   = 2'd2,
    OP_WRITE  = 2'd3
  } cpu_op_e;
endpackage

// File: rtl/dst_tag_store.sv
module dst_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic [TAG_W-1:0] cpu_tag,
  input  logic             cpu_fill,
  input  logic             cpu_wr,
  output logic             cpu_hit,
  output logic             cpu_dirty,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic             snp_inv,
  output logic             snp_hit,
  output logic             snp_dirty
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // two independent read ports: processor side and snoop side
  always_comb begin
    cpu_hit   = valid_q[cpu_idx] && (tag_q[cpu_idx] == cpu_tag);
    cpu_dirty = cpu_hit && dirty_q[cpu_idx];
    snp_hit   = valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
    snp_dirty = snp_hit && dirty_q[snp_idx];
  end

  // state bits; the snoop purge is applied last so it wins on a shared index
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (cpu_fill) begin
        valid_q[cpu_idx] <= 1'b1;
        dirty_q[cpu_idx] <= 1'b0;
      end else if (cpu_wr && cpu_hit) begin
        dirty_q[cpu_idx] <= 1'b1;
      end
      if (snp_inv) begin
        valid_q[snp_idx] <= 1'b0;
        dirty_q[snp_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_fill) tag_q[cpu_idx] <= cpu_tag;
  end

  AST_SNOOP_INV_WINS: assert property (@(posedge clk) disable iff (rst)
    snp_inv |=> !valid_q[$past(snp_idx)]); // R10
  AST_WRITE_MISS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_hit && !snp_inv) |=> ($stable(valid_q) && $stable(dirty_q))); // R3
endmodule

// File: rtl/dst_data_ram.sv
module dst_data_ram #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] mem [LINES];

  // simple dual-port, read-first, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dst_snoop_ctrl.sv
module dst_snoop_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic              snp_hit,
  input  logic              snp_dirty,
  input  logic [DATA_W-1:0] line_data,
  output logic              snp_inv,
  output logic              mem_inhibit,
  output logic              bus_drive,
  output logic [DATA_W-1:0] bus_data_out
);
  logic intervene;

  always_comb begin
    intervene = bus_valid && !bus_we && snp_hit && snp_dirty;
    snp_inv   = bus_valid && bus_we && snp_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_inhibit  <= 1'b0;
      bus_drive    <= 1'b0;
      bus_data_out <= '0;
    end else begin
      mem_inhibit  <= intervene;
      bus_drive    <= mem_inhibit;
      bus_data_out <= mem_inhibit ? line_data : '0;
    end
  end

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !snp_hit) |=> !mem_inhibit); // R4
  AST_CLEAN_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && !snp_dirty) |=> !mem_inhibit); // R5
  AST_INHIBIT_THEN_DRIVE: assert property (@(posedge clk) disable iff (rst)
    mem_inhibit |=> bus_drive); // R6
  AST_DMA_WRITE_NO_INTERVENE: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we) |=> !mem_inhibit); // R8
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_drive |-> (bus_data_out == '0)); // R9
endmodule

// File: rtl/dma_snoop_tags.sv
module dma_snoop_tags #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_resp_valid,
  output logic              cpu_hit,
  output logic              cpu_dirty,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              mem_inhibit,
  output logic              bus_drive,
  output logic [DATA_W-1:0] bus_data_out
);
  import dst_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W;

  cpu_op_e           op;
  logic              is_fill, is_wr, any_op;
  logic              hit_now, dirty_now;
  logic              snp_hit, snp_dirty, snp_inv;
  logic [DATA_W-1:0] line_data;

  always_comb begin
    op      = cpu_op_e'(cpu_op);
    is_fill = (op == OP_FILL);
    is_wr   = (op == OP_WRITE);
    any_op  = (op != OP_NOP);
  end

  dst_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .cpu_idx   (cpu_addr[IDX_W-1:0]),
    .cpu_tag   (cpu_addr[ADDR_W-1:IDX_W]),
    .cpu_fill  (is_fill),
    .cpu_wr    (is_wr),
    .cpu_hit   (hit_now),
    .cpu_dirty (dirty_now),
    .snp_idx   (bus_addr[IDX_W-1:0]),
    .snp_tag   (bus_addr[ADDR_W-1:IDX_W]),
    .snp_inv   (snp_inv),
    .snp_hit   (snp_hit),
    .snp_dirty (snp_dirty)
  );

  dst_data_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .we    (is_fill || (is_wr && hit_now)),
    .waddr (cpu_addr[IDX_W-1:0]),
    .wdata (cpu_wdata),
    .raddr (bus_addr[IDX_W-1:0]),
    .rdata (line_data)
  );

  dst_snoop_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .bus_valid    (bus_valid),
    .bus_we       (bus_we),
    .snp_hit      (snp_hit),
    .snp_dirty    (snp_dirty),
    .line_data    (line_data),
    .snp_inv      (snp_inv),
    .mem_inhibit  (mem_inhibit),
    .bus_drive    (bus_drive),
    .bus_data_out (bus_data_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_resp_valid <= 1'b0;
      cpu_hit        <= 1'b0;
      cpu_dirty      <= 1'b0;
    end else begin
      cpu_resp_valid <= any_op;
      cpu_hit        <= any_op && hit_now;
      cpu_dirty      <= any_op && dirty_now;
    end
  end

  AST_RESP_ONLY_AFTER_OP: assert property (@(posedge clk) disable iff (rst)
    cpu_hit |-> cpu_resp_valid); // R2
endmodule

// File: tb/dma_snoop_tags_bench.sv
module dma_snoop_tags_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cpu_op = 2'd0;
  logic [11:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_resp_valid, cpu_hit, cpu_dirty;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        mem_inhibit, bus_drive;
  logic [31:0] bus_data_out;

  always #2.5 clk = ~clk;

  dma_snoop_tags u_dma_snoop_tags (
    .clk(clk), .rst(rst), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_resp_valid(cpu_resp_valid),
    .cpu_hit(cpu_hit), .cpu_dirty(cpu_dirty), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .mem_inhibit(mem_inhibit),
    .bus_drive(bus_drive), .bus_data_out(bus_data_out)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state per line
  bit          mv [16];
  bit          md [16];
  int          mt [16];
  logic [31:0] mdat [16];
  bit          pend_drv = 0;
  logic [31:0] pend_dat = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check at the following negedge
  task automatic step(input logic [1:0] op, input int a, input logic [31:0] wd,
                      input bit bv, input bit bwe, input int ba, input string rq);
    int ci, ct, si, st;
    bit chit, cdty, shit, inh;
    logic [31:0] sdat;
    ci = a % 16; ct = a / 16; si = ba % 16; st = ba / 16;
    chit = mv[ci] && (mt[ci] == ct);
    cdty = chit && md[ci];
    shit = bv && mv[si] && (mt[si] == st);
    inh  = shit && !bwe && md[si];
    sdat = mdat[si];
    cpu_op = op; cpu_addr = 12'(a); cpu_wdata = wd;
    bus_valid = bv; bus_we = bwe; bus_addr = 12'(ba);
    if (op == 2'd2) begin
      mv[ci] = 1; md[ci] = 0; mt[ci] = ct; mdat[ci] = wd;
    end else if (op == 2'd3 && chit) begin
      md[ci] = 1; mdat[ci] = wd;
    end
    if (shit && bwe) begin
      mv[si] = 0; md[si] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(cpu_resp_valid == (op != 2'd0), rq, "resp_valid", 64'(cpu_resp_valid), 64'(op != 2'd0));
    chk(cpu_hit == (op != 2'd0 && chit), rq, "cpu_hit", 64'(cpu_hit), 64'(op != 2'd0 && chit));
    chk(cpu_dirty == (op != 2'd0 && cdty), rq, "cpu_dirty", 64'(cpu_dirty), 64'(op != 2'd0 && cdty));
    chk(mem_inhibit == inh, rq, "mem_inhibit", 64'(mem_inhibit), 64'(inh));
    chk(bus_drive == pend_drv, rq, "bus_drive", 64'(bus_drive), 64'(pend_drv));
    chk(bus_data_out == (pend_drv ? pend_dat : 32'h0), rq, "bus_data_out (R9)",
        64'(bus_data_out), 64'(pend_drv ? pend_dat : 32'h0));
    pend_drv = inh;
    pend_dat = sdat;
    cpu_op = 2'd0; bus_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mv[i] = 0; md[i] = 0; mt[i] = 0; mdat[i] = '0;
    end
    void'($urandom(32'd20110));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: outputs idle after reset
    chk(!cpu_resp_valid && !cpu_hit && !cpu_dirty, "R1", "cpu outputs", 64'({cpu_resp_valid, cpu_hit, cpu_dirty}), 0);
    chk(!mem_inhibit && !bus_drive && bus_data_out == 0, "R1", "bus outputs", 64'(bus_data_out), 0);
    step(2'd1, 'h015, 0, 0, 0, 0, "R1");
    step(2'd1, 'h0A3, 0, 0, 0, 0, "R1");
    // R2 fill / lookup
    step(2'd2, 'h015, 32'hAAAA_0001, 0, 0, 0, "R2");
    step(2'd1, 'h015, 0, 0, 0, 0, "R2");
    step(2'd1, 'h025, 0, 0, 0, 0, "R2");
    // R3 write miss and write hit
    step(2'd3, 'h037, 32'hDEAD_0000, 0, 0, 0, "R3");
    step(2'd1, 'h037, 0, 0, 0, 0, "R3");
    step(2'd3, 'h015, 32'hBBBB_0002, 0, 0, 0, "R3");
    step(2'd1, 'h015, 0, 0, 0, 0, "R3");
    step(2'd2, 'h018, 32'hCCCC_0003, 0, 0, 0, "R3");
    // R4 snoop miss
    step(2'd0, 0, 0, 1, 0, 'h099, "R4");
    step(2'd0, 0, 0, 1, 1, 'h028, "R4");
    step(2'd1, 'h018, 0, 0, 0, 0, "R4");
    // R5 read hit clean
    step(2'd0, 0, 0, 1, 0, 'h018, "R5");
    step(2'd1, 'h018, 0, 0, 0, 0, "R5");
    // R6 read hit dirty: inhibit, then drive
    step(2'd0, 0, 0, 1, 0, 'h015, "R6");
    step(2'd0, 0, 0, 0, 0, 0, "R6");
    step(2'd0, 0, 0, 0, 0, 0, "R9");
    step(2'd1, 'h015, 0, 0, 0, 0, "R6");
    // R7 write hit clean
    step(2'd0, 0, 0, 1, 1, 'h018, "R7");
    step(2'd1, 'h018, 0, 0, 0, 0, "R7");
    // R8 write hit dirty
    step(2'd0, 0, 0, 1, 1, 'h015, "R8");
    step(2'd1, 'h015, 0, 0, 0, 0, "R8");
    // R10 same-index collision
    step(2'd2, 'h02A, 32'h1111_0000, 0, 0, 0, "R10");
    step(2'd2, 'h02A, 32'h2222_0000, 1, 1, 'h02A, "R10");
    step(2'd1, 'h02A, 0, 0, 0, 0, "R10");
    step(2'd2, 'h03C, 32'h3333_0000, 0, 0, 0, "R10");
    step(2'd3, 'h03C, 32'h4444_0000, 1, 1, 'h03C, "R10");
    step(2'd1, 'h03C, 0, 0, 0, 0, "R10");
    // R11 both ports in one cycle
    step(2'd2, 'h03B, 32'h5555_0000, 0, 0, 0, "R11");
    step(2'd3, 'h03B, 32'h6666_0000, 0, 0, 0, "R11");
    step(2'd3, 'h03B, 32'h7777_0000, 1, 0, 'h03B, "R11");
    step(2'd1, 'h03B, 0, 1, 0, 'h03B, "R11");
    step(2'd0, 0, 0, 0, 0, 0, "R11");
    // random mix over a small address space
    for (int n = 0; n < 3000; n++) begin
      int a, ba;
      a  = int'($urandom % 3) * 16 + int'($urandom % 8);
      ba = int'($urandom % 3) * 16 + int'($urandom % 8);
      step(2'($urandom % 4), a, $urandom, bit'($urandom % 2), bit'($urandom % 2), ba, "R11");
    end
    step(2'd0, 0, 0, 0, 0, 0, "R9");
    step(2'd0, 0, 0, 0, 0, 0, "R9");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule